// File: doc/BRIEF.md
# Transmit Overhead Byte Corruptor

This block sits on the transmit path between the source of section and line overhead bytes and the processor that places them into the outgoing frame. For every overhead byte presented, it takes the value either from a hardware parallel bus or from a software-written byte. It then optionally damages selected bytes on purpose, so that downstream equipment and alarm logic can be exercised. The output is one registered byte per input byte.

Three kinds of diagnostic damage are supported. Framing bytes (first and second framing pattern) are XORed with a pattern when a per-byte mark is set. The section parity byte is XORed with a mask once, after a one-shot software request. The line parity bytes are damaged through a coarse byte-group select, in which each bit covers four consecutive bytes, together with a bit-inversion mask. Each set of masks is captured only at a frame-aligned instant, so software writes never split a frame. Parity computation and scrambling happen elsewhere. This block only sees the already computed bytes.

Each byte is tagged with a 3-bit kind code. The block keeps its own per-frame index for the framing and line-parity bytes. The index restarts on the frame-start strobe.

Top module: `toh_err_inject`

## Requirements
- R1: One cycle after a cycle with `byte_vld` high, `out_vld` is high. One cycle after a cycle with `byte_vld` low, `out_vld` is low. The source byte is `sw_byte` when `src_sel`=1 and `hw_byte` when `src_sel`=0.
- R2: Bytes whose `slot_kind` is not 1 (first framing byte), 2 (second framing byte), 3 (section parity) or 4 (line parity) are output unchanged. This includes code 0 and codes 5 to 7.
- R3: The i-th first-framing byte of a frame (i counted from 0, i < N_A1) is XORed with the pattern when mask bit i is set. The j-th second-framing byte (j < N_A2) is XORed with the pattern when mask bit N_A1+j is set.
- R4: The framing mask and pattern are captured only in the cycle where `frame_start` is high, and they apply from that cycle on. Input changes at any other time have no effect until the next frame start.
- R5: A `b1_ins` pulse arms a one-shot and captures `b1_mask`. The next section-parity byte in a later cycle is XORed with the captured mask. Section-parity bytes after that pass unchanged until the next pulse.
- R6: Line-parity byte n of a frame (n < N_B2) has the bits of `b2_bit_mask` inverted when bit n/4 of the byte mask is set.
- R7: The line-parity enable and both line-parity masks are captured at the first line-parity byte of each frame (index 0), and they apply to that byte. Later changes have no effect within the frame. If the enable is low at that instant, no line-parity byte of the frame is damaged.
- R8: After reset, `out_vld` and `out_byte` are 0, the one-shot is disarmed and the held masks are zero. Until the first frame start, no framing byte is damaged.
- R9: Framing bytes beyond index N_A1-1 (or N_A2-1) and line-parity bytes beyond index N_B2-1 in a frame pass unchanged.
- R10: `out_byte` is 0 whenever `out_vld` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Frame-boundary strobe; restarts byte indices |
| byte_vld | input | 1 | An overhead byte is present this cycle |
| slot_kind | input | 3 | Byte kind: 0 other, 1 first framing, 2 second framing, 3 section parity, 4 line parity |
| src_sel | input | 1 | 1 selects the software byte, 0 the hardware byte |
| hw_byte | input | 8 | Hardware parallel overhead byte |
| sw_byte | input | 8 | Software-written overhead byte |
| a1a2_mask | input | N_A1+N_A2 | Per-byte framing damage marks |
| a1a2_pat | input | 8 | XOR pattern for marked framing bytes |
| b1_ins | input | 1 | One-shot section-parity damage request |
| b1_mask | input | 8 | XOR mask for the section-parity byte |
| b2_en | input | 1 | Line-parity damage enable |
| b2_byte_mask | input | N_B2/4 | Byte-group select, one bit per four bytes |
| b2_bit_mask | input | 8 | Bits inverted in selected line-parity bytes |
| out_vld | output | 1 | Output byte valid |
| out_byte | output | 8 | Output overhead byte |

## Verification
The embedded properties check the following on every cycle:
- the valid output follows the valid input by one cycle, and the output byte is zero when idle;
- unlisted byte kinds pass straight through;
- the held framing masks and line-parity masks change only at their capture instants;
- the section-parity one-shot arms on request and disarms after one use;
- the per-frame counters saturate.

The bench's directed frames are needed for the rest:
- the exact byte-to-mask-bit mapping, including the four-byte grouping of the line-parity mask;
- that a mask change in mid-frame only takes effect at the next capture;
- that a disabled line-parity capture spares the whole frame;
- that bytes past the parameterized counts stay clean.

// File: rtl/toh_inj_pkg.sv
package toh_inj_pkg;
  typedef enum logic [2:0] {
    K_OTHER = 3'd0,
    K_A1    = 3'd1,
    K_A2    = 3'd2,
    K_B1    = 3'd3,
    K_B2    = 3'd4
  } slot_kind_e;
endpackage

// File: rtl/toh_slot_ctr.sv
// Per-frame index of one byte kind; restarts on frame_start, saturates at MAXCNT.
module toh_slot_ctr #(
  parameter int MAXCNT = 4,
  localparam int W = $clog2(MAXCNT + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         frame_start,
  input  logic         hit,
  output logic [W-1:0] idx
);
  logic [W-1:0] cnt_q;

  assign idx = frame_start ? '0 : cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                                cnt_q <= '0;
    else if (hit && idx != W'(MAXCNT))      cnt_q <= idx + W'(1);
    else                                    cnt_q <= idx;
  end

  // R9: saturated index stays saturated within a frame
  p_ctr_sat_r9: assert property (@(posedge clk) disable iff (rst)
    (hit && !frame_start && cnt_q == W'(MAXCNT)) |=> (cnt_q == W'(MAXCNT)));
endmodule

// File: rtl/toh_a1a2_masker.sv
// Framing-byte damage: per-byte marks and a pattern captured at frame start.
module toh_a1a2_masker #(
  parameter int N_A1 = 3,
  parameter int N_A2 = 3,
  localparam int NM  = N_A1 + N_A2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          frame_start,
  input  logic          is_a1,
  input  logic          is_a2,
  input  logic [NM-1:0] mask_in,
  input  logic [7:0]    pat_in,
  output logic [7:0]    xor_out
);
  localparam int W1 = $clog2(N_A1 + 1);
  localparam int W2 = $clog2(N_A2 + 1);

  logic [W1-1:0] a1_idx;
  logic [W2-1:0] a2_idx;
  logic [NM-1:0] mask_q, eff_mask;
  logic [7:0]    pat_q, eff_pat;
  logic          sel;

  toh_slot_ctr #(.MAXCNT(N_A1)) u_a1_ctr (
    .clk(clk), .rst(rst), .frame_start(frame_start), .hit(is_a1), .idx(a1_idx));
  toh_slot_ctr #(.MAXCNT(N_A2)) u_a2_ctr (
    .clk(clk), .rst(rst), .frame_start(frame_start), .hit(is_a2), .idx(a2_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      pat_q  <= '0;
    end else if (frame_start) begin
      mask_q <= mask_in;
      pat_q  <= pat_in;
    end
  end

  assign eff_mask = frame_start ? mask_in : mask_q;
  assign eff_pat  = frame_start ? pat_in  : pat_q;

  always_comb begin
    sel = 1'b0;
    for (int i = 0; i < N_A1; i++)
      if (is_a1 && a1_idx == W1'(i) && eff_mask[i]) sel = 1'b1;
    for (int j = 0; j < N_A2; j++)
      if (is_a2 && a2_idx == W2'(j) && eff_mask[N_A1 + j]) sel = 1'b1;
  end

  assign xor_out = sel ? eff_pat : 8'h00;

  // R4: held framing masks move only at a frame start
  p_mask_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> ($stable(mask_q) && $stable(pat_q)));
endmodule

// File: rtl/toh_b1_arm.sv
// Section-parity one-shot: a request arms it, the next parity byte consumes it.
module toh_b1_arm (
  input  logic       clk,
  input  logic       rst,
  input  logic       req,
  input  logic [7:0] mask_in,
  input  logic       is_b1,
  output logic [7:0] xor_out
);
  logic       armed_q;
  logic [7:0] pat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      pat_q   <= '0;
    end else if (req) begin
      armed_q <= 1'b1;
      pat_q   <= mask_in;
    end else if (is_b1 && armed_q) begin
      armed_q <= 1'b0;
    end
  end

  assign xor_out = (is_b1 && armed_q) ? pat_q : 8'h00;

  // R5: a request always arms
  p_b1_arm_r5: assert property (@(posedge clk) disable iff (rst)
    req |=> armed_q);
  // R5: one use disarms
  p_b1_oneshot_r5: assert property (@(posedge clk) disable iff (rst)
    (is_b1 && armed_q && !req) |=> !armed_q);
endmodule

// File: rtl/toh_b2_masker.sv
// Line-parity damage: group select (4 bytes per bit) plus bit mask, captured at byte 0.
module toh_b2_masker #(
  parameter int N_B2 = 12,
  localparam int N_SLOT = N_B2 / 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_start,
  input  logic              is_b2,
  input  logic              en_in,
  input  logic [N_SLOT-1:0] byte_mask_in,
  input  logic [7:0]        bit_mask_in,
  output logic [7:0]        xor_out
);
  localparam int W = $clog2(N_B2 + 1);

  logic [W-1:0]      idx;
  logic              first;
  logic [N_SLOT-1:0] bmask_q, eff_bmask;
  logic [7:0]        bit_q, eff_bit;
  logic [N_B2-1:0]   byte_en;
  logic              hit;

  toh_slot_ctr #(.MAXCNT(N_B2)) u_b2_ctr (
    .clk(clk), .rst(rst), .frame_start(frame_start), .hit(is_b2), .idx(idx));

  assign first = is_b2 && (idx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      bmask_q <= '0;
      bit_q   <= '0;
    end else if (first) begin
      bmask_q <= en_in ? byte_mask_in : '0;
      bit_q   <= bit_mask_in;
    end
  end

  assign eff_bmask = first ? (en_in ? byte_mask_in : '0) : bmask_q;
  assign eff_bit   = first ? bit_mask_in : bit_q;

  for (genvar n = 0; n < N_B2; n++) begin : g_expand
    assign byte_en[n] = eff_bmask[n / 4];
  end

  always_comb begin
    hit = 1'b0;
    for (int n = 0; n < N_B2; n++)
      if (is_b2 && idx == W'(n) && byte_en[n]) hit = 1'b1;
  end

  assign xor_out = hit ? eff_bit : 8'h00;

  // R7: held line-parity masks move only at the first line-parity byte
  p_b2_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !first |=> ($stable(bmask_q) && $stable(bit_q)));
endmodule

// File: rtl/toh_err_inject.sv
module toh_err_inject
  import toh_inj_pkg::*;
#(
  parameter int N_A1 = 3,
  parameter int N_A2 = 3,
  parameter int N_B2 = 12
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   frame_start,
  input  logic                   byte_vld,
  input  logic [2:0]             slot_kind,
  input  logic                   src_sel,
  input  logic [7:0]             hw_byte,
  input  logic [7:0]             sw_byte,
  input  logic [N_A1+N_A2-1:0]   a1a2_mask,
  input  logic [7:0]             a1a2_pat,
  input  logic                   b1_ins,
  input  logic [7:0]             b1_mask,
  input  logic                   b2_en,
  input  logic [N_B2/4-1:0]      b2_byte_mask,
  input  logic [7:0]             b2_bit_mask,
  output logic                   out_vld,
  output logic [7:0]             out_byte
);
  slot_kind_e kind;
  logic       is_a1, is_a2, is_b1, is_b2, is_other;
  logic [7:0] src, a_x, b1_x, b2_x, nxt;

  assign kind     = slot_kind_e'(slot_kind);
  assign is_a1    = byte_vld && kind == K_A1;
  assign is_a2    = byte_vld && kind == K_A2;
  assign is_b1    = byte_vld && kind == K_B1;
  assign is_b2    = byte_vld && kind == K_B2;
  assign is_other = byte_vld && !(is_a1 || is_a2 || is_b1 || is_b2);
  assign src      = src_sel ? sw_byte : hw_byte;

  toh_a1a2_masker #(.N_A1(N_A1), .N_A2(N_A2)) u_a1a2 (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .is_a1(is_a1), .is_a2(is_a2),
    .mask_in(a1a2_mask), .pat_in(a1a2_pat), .xor_out(a_x));

  toh_b1_arm u_b1 (
    .clk(clk), .rst(rst), .req(b1_ins), .mask_in(b1_mask),
    .is_b1(is_b1), .xor_out(b1_x));

  toh_b2_masker #(.N_B2(N_B2)) u_b2 (
    .clk(clk), .rst(rst), .frame_start(frame_start), .is_b2(is_b2),
    .en_in(b2_en), .byte_mask_in(b2_byte_mask), .bit_mask_in(b2_bit_mask),
    .xor_out(b2_x));

  assign nxt = src ^ a_x ^ b1_x ^ b2_x;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_byte <= 8'h00;
    end else begin
      out_vld  <= byte_vld;
      out_byte <= byte_vld ? nxt : 8'h00;
    end
  end

  // R1: valid follows input valid one cycle later
  p_vld_rise_r1: assert property (@(posedge clk) disable iff (rst)
    byte_vld |=> out_vld);
  p_vld_fall_r1: assert property (@(posedge clk) disable iff (rst)
    !byte_vld |=> !out_vld);
  // R10: idle output is zero
  p_idle_zero_r10: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> (out_byte == 8'h00));
  // R2: unlisted kinds pass the selected source unchanged
  p_other_pass_r2: assert property (@(posedge clk) disable iff (rst)
    is_other |=> (out_byte == $past(src_sel ? sw_byte : hw_byte)));
endmodule

// File: tb/toh_err_inject_test.sv
`timescale 1ns/1ps
module toh_err_inject_test;
  localparam int NA1 = 3;
  localparam int NA2 = 3;
  localparam int NB2 = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_start = 0, byte_vld = 0, src_sel = 0, b1_ins = 0, b2_en = 0;
  logic [2:0] slot_kind = 0;
  logic [7:0] hw_byte = 0, sw_byte = 0, a1a2_pat = 0, b1_mask = 0, b2_bit_mask = 0;
  logic [NA1+NA2-1:0] a1a2_mask = 0;
  logic [NB2/4-1:0] b2_byte_mask = 0;
  logic out_vld;
  logic [7:0] out_byte;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  toh_err_inject #(.N_A1(NA1), .N_A2(NA2), .N_B2(NB2)) uut (
    .clk(clk), .rst(rst), .frame_start(frame_start), .byte_vld(byte_vld),
    .slot_kind(slot_kind), .src_sel(src_sel), .hw_byte(hw_byte), .sw_byte(sw_byte),
    .a1a2_mask(a1a2_mask), .a1a2_pat(a1a2_pat), .b1_ins(b1_ins), .b1_mask(b1_mask),
    .b2_en(b2_en), .b2_byte_mask(b2_byte_mask), .b2_bit_mask(b2_bit_mask),
    .out_vld(out_vld), .out_byte(out_byte));

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  // one idle cycle; inputs already set by caller are applied at this edge
  task automatic tick();
    @(posedge clk); #1;
    frame_start = 0; b1_ins = 0; byte_vld = 0;
  endtask

  task automatic frame();
    frame_start = 1;
    tick();
  endtask

  task automatic send(input logic [2:0] k, input logic [7:0] hw, input logic [7:0] sw,
                      input logic sel, output logic [7:0] got, output logic vld);
    byte_vld = 1; slot_kind = k; hw_byte = hw; sw_byte = sw; src_sel = sel;
    @(posedge clk); #1;
    got = out_byte; vld = out_vld;
    byte_vld = 0; frame_start = 0; b1_ins = 0;
  endtask

  task automatic t_reset();
    logic [7:0] g; logic v;
    chk("R8 out_vld", {7'd0, out_vld}, 8'h00);
    chk("R8 out_byte", out_byte, 8'h00);
    a1a2_mask = '1; a1a2_pat = 8'hFF;           // not captured: no frame start yet
    send(3'd1, 8'hF6, 8'h00, 0, g, v);
    chk("R8 framing clean before first frame", g, 8'hF6);
  endtask

  task automatic t_src();
    logic [7:0] g; logic v;
    send(3'd0, 8'h12, 8'h34, 0, g, v);
    chk("R1 hw source", g, 8'h12);
    chk("R1 out_vld", {7'd0, v}, 8'h01);
    send(3'd0, 8'h12, 8'h34, 1, g, v);
    chk("R1 sw source", g, 8'h34);
    send(3'd7, 8'hA5, 8'h00, 0, g, v);
    chk("R2 code 7 passes", g, 8'hA5);
    send(3'd5, 8'h00, 8'h5A, 1, g, v);
    chk("R2 code 5 passes", g, 8'h5A);
    tick();
    chk("R10 idle vld", {7'd0, out_vld}, 8'h00);
    chk("R10 idle byte", out_byte, 8'h00);
  endtask

  task automatic t_a1a2();
    logic [7:0] g; logic v;
    logic [NA1+NA2-1:0] m;
    m = 6'b100101;
    a1a2_mask = m; a1a2_pat = 8'h0F;
    frame();
    a1a2_mask = '0; a1a2_pat = 8'h00;           // after capture: must not matter (R4)
    for (int i = 0; i < NA1; i++) begin
      send(3'd1, 8'h00, 8'hF6, 1, g, v);
      chk("R3 first framing byte", g, m[i] ? (8'hF6 ^ 8'h0F) : 8'hF6);
    end
    for (int j = 0; j < NA2; j++) begin
      send(3'd2, 8'h28, 8'h00, 0, g, v);
      chk("R3 second framing byte", g, m[NA1+j] ? (8'h28 ^ 8'h0F) : 8'h28);
    end
    send(3'd1, 8'h00, 8'hF6, 1, g, v);
    chk("R9 extra framing byte clean", g, 8'hF6);
  endtask

  task automatic t_a1a2_hold();
    logic [7:0] g; logic v;
    a1a2_mask = 6'b000011; a1a2_pat = 8'hA0;
    frame();
    a1a2_mask = '1; a1a2_pat = 8'hFF;
    send(3'd1, 8'h11, 8'h00, 0, g, v);
    chk("R4 held mask byte0", g, 8'h11 ^ 8'hA0);
    send(3'd1, 8'h11, 8'h00, 0, g, v);
    chk("R4 held mask byte1", g, 8'h11 ^ 8'hA0);
    send(3'd1, 8'h11, 8'h00, 0, g, v);
    chk("R4 mid-frame write ignored", g, 8'h11);
    frame();
    a1a2_mask = '0;
    send(3'd1, 8'h11, 8'h00, 0, g, v);
    send(3'd1, 8'h11, 8'h00, 0, g, v);
    send(3'd1, 8'h11, 8'h00, 0, g, v);
    chk("R4 new mask at next frame", g, 8'h11 ^ 8'hFF);
  endtask

  task automatic t_b1();
    logic [7:0] g; logic v;
    send(3'd3, 8'h55, 8'h00, 0, g, v);
    chk("R5 unarmed parity clean", g, 8'h55);
    b1_mask = 8'h81; b1_ins = 1;
    tick();
    b1_mask = 8'hFF;
    send(3'd0, 8'h33, 8'h00, 0, g, v);
    chk("R5 other byte not consumed", g, 8'h33);
    send(3'd3, 8'h55, 8'h00, 0, g, v);
    chk("R5 armed parity damaged", g, 8'h55 ^ 8'h81);
    send(3'd3, 8'h55, 8'h00, 0, g, v);
    chk("R5 one-shot cleared", g, 8'h55);
  endtask

  task automatic t_b2();
    logic [7:0] g; logic v;
    logic [NB2/4-1:0] bm;
    bm = 3'b101;
    b2_en = 1; b2_byte_mask = bm; b2_bit_mask = 8'h3C;
    frame();
    for (int n = 0; n < NB2 + 1; n++) begin
      send(3'd4, 8'h99, 8'h00, 0, g, v);
      if (n == 0) begin
        b2_byte_mask = '1; b2_bit_mask = 8'hFF; b2_en = 0;
      end
      if (n >= NB2)
        chk("R9 extra line parity clean", g, 8'h99);
      else if (n == 0)
        chk("R7 capture at first byte", g, 8'h99 ^ 8'h3C);
      else
        chk("R6 line parity group", g, bm[n/4] ? (8'h99 ^ 8'h3C) : 8'h99);
    end
  endtask

  task automatic t_b2_off();
    logic [7:0] g; logic v;
    b2_en = 0; b2_byte_mask = '1; b2_bit_mask = 8'hFF;
    frame();
    send(3'd4, 8'h42, 8'h00, 0, g, v);
    chk("R7 disabled at capture byte0", g, 8'h42);
    b2_en = 1;
    for (int n = 1; n < 6; n++) begin
      send(3'd4, 8'h42, 8'h00, 0, g, v);
      chk("R7 late enable ignored", g, 8'h42);
    end
    frame();
    send(3'd4, 8'h42, 8'h00, 0, g, v);
    chk("R6 enabled next frame", g, 8'h42 ^ 8'hFF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 0;
    t_reset();
    t_src();
    t_a1a2();
    t_a1a2_hold();
    t_b1();
    t_b2();
    t_b2_off();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule